// File: doc/BRIEF.md
# SD Host Status and Interrupt Flag Register

This block holds the event flags of a small SD/MMC host controller. Single-cycle event pulses from the command, data and card-presence logic set sticky flags at fixed bit positions in a 32-bit status word. Three live level inputs (bus clock running, buffer read-ready, buffer write-ready) appear in the same word as they are, without latching. A 2-bit write-CRC status code from the data path is also held in the word. The code value 2 means that the card sent no CRC status, and software treats that case as a timeout rather than as a CRC error.

Software reads the status word and the interrupt-enable word over a simple register bus. The read data is a combinational function of the address. Software acknowledges flags by writing ones to the status address. Two outputs summarise the state. `err_o` is the OR of the five error flags, and it is not masked. `irq_o` is raised when any sticky flag is set and its enable bit at the same position is also set.

Top module: `sdh_stat_reg`

## Requirements
- R1: After a synchronous reset, the status word (with the live inputs low) reads 0, the enable word reads 0, and `irq_o` and `err_o` are low.
- R2: A one-cycle pulse on an event input sets its sticky flag, which reads as 1 from the cycle after the pulse until it is cleared. The bit positions are: read timeout 0, response timeout 1, write-CRC error 2, read CRC error 3, response CRC error 5, read/transfer done 11, write done 12, command-response end 13, buffer overflow 24, buffer underrun 25, card removal 30, card insertion 31.
- R3: A bus write to address 0 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Bits 8 (bus clock running), 7 (buffer read-ready) and 6 (buffer write-ready) follow their live inputs in the same cycle. Writes to address 0 have no effect on them.
- R6: `err_o` is high exactly when at least one of bits 0, 1, 2, 3 or 5 is set. Other flags and the enable word do not affect it.
- R7: The 2-bit input code is captured into bits 10:9 on a write-CRC error pulse and held there. Writing ones to bits 10:9 does not change it. Clearing bit 2 resets the code to 0, unless a new write-CRC pulse arrives in the same cycle.
- R8: The enable word is at address 1. Only the twelve flag positions listed in R2 are writable. All other bits of the enable word read 0.
- R9: `irq_o` is high exactly when some flag is set and its enable bit at the same position is 1. An all-zero enable word holds `irq_o` low.
- R10: Reads from addresses 2 and 3 return 0. Bit 4 and bits 14 to 23 and 26 to 29 of the status word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rd_to_i | input | 1 | Read timeout pulse |
| ev_resp_to_i | input | 1 | Response timeout pulse |
| ev_wr_crc_i | input | 1 | Write-CRC error pulse (captures code) |
| ev_rd_crc_i | input | 1 | Read CRC error pulse |
| ev_resp_crc_i | input | 1 | Response CRC error pulse |
| ev_rd_done_i | input | 1 | Read/transfer done pulse |
| ev_wr_done_i | input | 1 | Write done pulse |
| ev_cmd_end_i | input | 1 | Command-response end pulse |
| ev_ovfl_i | input | 1 | Buffer overflow pulse |
| ev_undr_i | input | 1 | Buffer underrun pulse |
| ev_rem_i | input | 1 | Card removal pulse |
| ev_ins_i | input | 1 | Card insertion pulse |
| wcrc_code_i | input | 2 | Write-CRC status code |
| clk_run_i | input | 1 | Live: card bus clock running |
| rd_rdy_i | input | 1 | Live: buffer read-ready |
| wr_rdy_i | input | 1 | Live: buffer write-ready |
| bus_addr | input | ADDR_W | Register address (0 status, 1 enable) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| err_o | output | 1 | Aggregate error |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions run on every cycle and cover the behaviour of each flag:
- an event sets the flag one cycle later;
- a clear with no competing event drops the flag;
- a flag with neither an event nor a clear holds its value;
- the code field holds its value when it is neither captured nor cleared;
- an error event raises `err_o`;
- an all-zero enable word keeps `irq_o` low.

Other properties can only be shown by the directed scenarios:
- the exact bit position of each flag in the word read back;
- live bits passing through while the rest of the word is written;
- the pattern of writable bits in the enable word;
- the result of an event and a clear arriving in the same cycle;
- zero data returned from the unused addresses.

// File: rtl/sdh_stat_pkg.sv
package sdh_stat_pkg;

    localparam int STAT_W = 32;

    // fixed bit positions, decoded by software
    localparam int B_RD_TO    = 0;
    localparam int B_RESP_TO  = 1;
    localparam int B_WR_CRC   = 2;
    localparam int B_RD_CRC   = 3;
    localparam int B_RESP_CRC = 5;
    localparam int B_WR_RDY   = 6;
    localparam int B_RD_RDY   = 7;
    localparam int B_CLK_RUN  = 8;
    localparam int B_CODE_LO  = 9;
    localparam int CODE_W     = 2;
    localparam int B_RD_DONE  = 11;
    localparam int B_WR_DONE  = 12;
    localparam int B_CMD_END  = 13;
    localparam int B_OVFL     = 24;
    localparam int B_UNDR     = 25;
    localparam int B_REM      = 30;
    localparam int B_INS      = 31;

    localparam int ADDR_STAT = 0;
    localparam int ADDR_EN   = 1;

    localparam logic [STAT_W-1:0] ERR_MASK  = 32'h0000_002F;
    localparam logic [STAT_W-1:0] FLAG_MASK = 32'hC300_382F;

    typedef struct packed {
        logic ins;
        logic rem;
        logic undr;
        logic ovfl;
        logic cmd_end;
        logic wr_done;
        logic rd_done;
        logic resp_crc;
        logic rd_crc;
        logic wr_crc;
        logic resp_to;
        logic rd_to;
    } sdh_evt_t;

    typedef struct packed {
        logic clk_run;
        logic rd_rdy;
        logic wr_rdy;
    } sdh_live_t;

    function automatic logic [STAT_W-1:0] evt_to_vec(input sdh_evt_t e);
        logic [STAT_W-1:0] v;
        v             = '0;
        v[B_RD_TO]    = e.rd_to;
        v[B_RESP_TO]  = e.resp_to;
        v[B_WR_CRC]   = e.wr_crc;
        v[B_RD_CRC]   = e.rd_crc;
        v[B_RESP_CRC] = e.resp_crc;
        v[B_RD_DONE]  = e.rd_done;
        v[B_WR_DONE]  = e.wr_done;
        v[B_CMD_END]  = e.cmd_end;
        v[B_OVFL]     = e.ovfl;
        v[B_UNDR]     = e.undr;
        v[B_REM]      = e.rem;
        v[B_INS]      = e.ins;
        return v;
    endfunction

    function automatic logic [STAT_W-1:0] build_word(
        input logic [STAT_W-1:0] flags,
        input logic [CODE_W-1:0] code,
        input sdh_live_t         live
    );
        logic [STAT_W-1:0] w;
        w = flags & FLAG_MASK;
        w[B_CODE_LO +: CODE_W] = code;
        w[B_CLK_RUN] = live.clk_run;
        w[B_RD_RDY]  = live.rd_rdy;
        w[B_WR_RDY]  = live.wr_rdy;
        return w;
    endfunction

endpackage

// File: rtl/sdh_stat_flags.sv
module sdh_stat_flags
    import sdh_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] flag_q
);

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (set_vec | (flag_q & ~clr_vec)) & FLAG_MASK;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_chk
        if (FLAG_MASK[i]) begin : g_flag
            AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> flag_q[i]);                              // R2
            AST_W1C_DROPS: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);            // R3
            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (!clr_vec[i] && !set_vec[i]) |=> $stable(flag_q[i]));   // R3
        end
    end

endmodule

// File: rtl/sdh_stat_code.sv
module sdh_stat_code
    import sdh_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    input  logic              clear,
    output logic [CODE_W-1:0] code_q
);

    always_ff @(posedge clk) begin
        if (rst)          code_q <= '0;
        else if (capture) code_q <= code_in;
        else if (clear)   code_q <= '0;
    end

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!capture && !clear) |=> $stable(code_q));                      // R7
    AST_CODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clear && !capture) |=> (code_q == '0));                        // R7

endmodule

// File: rtl/sdh_stat_irq.sv
module sdh_stat_irq
    import sdh_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic [STAT_W-1:0] en_wdata,
    input  logic [STAT_W-1:0] flags,
    output logic [STAT_W-1:0] en_q,
    output logic              irq_o,
    output logic              err_o
);

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_we) en_q <= en_wdata & FLAG_MASK;
    end

    assign irq_o = |(flags & en_q);
    assign err_o = |(flags & ERR_MASK);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_o);                                       // R9
    AST_EN_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en_q & ~FLAG_MASK) == '0);                                     // R8

endmodule

// File: rtl/sdh_stat_reg.sv
module sdh_stat_reg
    import sdh_stat_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_rd_to_i,
    input  logic              ev_resp_to_i,
    input  logic              ev_wr_crc_i,
    input  logic              ev_rd_crc_i,
    input  logic              ev_resp_crc_i,
    input  logic              ev_rd_done_i,
    input  logic              ev_wr_done_i,
    input  logic              ev_cmd_end_i,
    input  logic              ev_ovfl_i,
    input  logic              ev_undr_i,
    input  logic              ev_rem_i,
    input  logic              ev_ins_i,
    input  logic [1:0]        wcrc_code_i,
    input  logic              clk_run_i,
    input  logic              rd_rdy_i,
    input  logic              wr_rdy_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              err_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_EN);

    sdh_evt_t          evt;
    sdh_live_t         live;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] flag_q;
    logic [STAT_W-1:0] en_q;
    logic [CODE_W-1:0] code_q;
    logic              stat_we;
    logic              en_we;

    always_comb begin
        evt.rd_to    = ev_rd_to_i;
        evt.resp_to  = ev_resp_to_i;
        evt.wr_crc   = ev_wr_crc_i;
        evt.rd_crc   = ev_rd_crc_i;
        evt.resp_crc = ev_resp_crc_i;
        evt.rd_done  = ev_rd_done_i;
        evt.wr_done  = ev_wr_done_i;
        evt.cmd_end  = ev_cmd_end_i;
        evt.ovfl     = ev_ovfl_i;
        evt.undr     = ev_undr_i;
        evt.rem      = ev_rem_i;
        evt.ins      = ev_ins_i;
        live.clk_run = clk_run_i;
        live.rd_rdy  = rd_rdy_i;
        live.wr_rdy  = wr_rdy_i;
    end

    assign set_vec = evt_to_vec(evt);
    assign stat_we = bus_wr && (bus_addr == A_STAT);
    assign en_we   = bus_wr && (bus_addr == A_EN);
    assign clr_vec = stat_we ? bus_wdata : '0;

    sdh_stat_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_q  (flag_q)
    );

    sdh_stat_code u_code (
        .clk     (clk),
        .rst     (rst),
        .capture (ev_wr_crc_i),
        .code_in (wcrc_code_i),
        .clear   (clr_vec[B_WR_CRC]),
        .code_q  (code_q)
    );

    sdh_stat_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .en_we    (en_we),
        .en_wdata (bus_wdata),
        .flags    (flag_q),
        .en_q     (en_q),
        .irq_o    (irq_o),
        .err_o    (err_o)
    );

    always_comb begin
        if (bus_addr == A_STAT)    bus_rdata = build_word(flag_q, code_q, live);
        else if (bus_addr == A_EN) bus_rdata = en_q;
        else                       bus_rdata = '0;
    end

    AST_ERR_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (ev_rd_to_i || ev_resp_to_i) |=> err_o);                        // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ev_cmd_end_i && stat_we && bus_wdata[B_CMD_END]) |=> flag_q[B_CMD_END]); // R4

endmodule

// File: tb/sdh_stat_reg_tb.sv
module sdh_stat_reg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ev = '0;
    logic [1:0]  code_in = '0;
    logic        clk_run = 1'b0, rd_rdy = 1'b0, wr_rdy = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err_o, irq_o;
    int          nchk = 0;
    int          nfail = 0;

    always #2 clk = ~clk;

    sdh_stat_reg u_dut (
        .clk(clk), .rst(rst),
        .ev_rd_to_i(ev[0]), .ev_resp_to_i(ev[1]), .ev_wr_crc_i(ev[2]),
        .ev_rd_crc_i(ev[3]), .ev_resp_crc_i(ev[4]), .ev_rd_done_i(ev[5]),
        .ev_wr_done_i(ev[6]), .ev_cmd_end_i(ev[7]), .ev_ovfl_i(ev[8]),
        .ev_undr_i(ev[9]), .ev_rem_i(ev[10]), .ev_ins_i(ev[11]),
        .wcrc_code_i(code_in), .clk_run_i(clk_run), .rd_rdy_i(rd_rdy),
        .wr_rdy_i(wr_rdy), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .err_o(err_o), .irq_o(irq_o)
    );

    function automatic int pos_of(input int k);
        case (k)
            0: return 0;   1: return 1;   2: return 2;   3: return 3;
            4: return 5;   5: return 11;  6: return 12;  7: return 13;
            8: return 24;  9: return 25;  10: return 30; default: return 31;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [11:0] v);
        @(negedge clk);
        ev = v;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 err", {31'b0, err_o}, 32'h0);
    endtask

    task automatic t_each_flag();
        logic [31:0] v;
        for (int k = 0; k < 12; k++) begin
            pulse(12'(1 << k));
            rd(2'd0, v);
            chk("R2 flag position", v, 32'(1) << pos_of(k));
            chk("R6 err level", {31'b0, err_o},
                {31'b0, (32'h2F & (32'(1) << pos_of(k))) != 0});
            wreg(2'd0, 32'(1) << pos_of(k));
            rd(2'd0, v);
            chk("R3 flag cleared", v, 32'h0);
        end
    endtask

    task automatic t_partial_clear();
        logic [31:0] v;
        pulse(12'h081);                       // cmd end + read timeout
        wreg(2'd0, 32'h0);
        rd(2'd0, v); chk("R3 zero write keeps", v, 32'h0000_2001);
        wreg(2'd0, 32'h0000_2000);
        rd(2'd0, v); chk("R3 selective clear", v, 32'h0000_0001);
        chk("R6 err from timeout", {31'b0, err_o}, 32'h1);
        wreg(2'd0, 32'h1);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse(12'h040);                       // write done
        @(negedge clk);
        ev = 12'h040; addr = 2'd0; wdata = 32'h0000_1000; wr = 1'b1;
        @(negedge clk);
        ev = '0; wr = 1'b0; wdata = '0;
        rd(2'd0, v); chk("R4 set beats clear", v, 32'h0000_1000);
        wreg(2'd0, 32'h0000_1000);
    endtask

    task automatic t_live();
        logic [31:0] v;
        @(negedge clk);
        clk_run = 1'b1; rd_rdy = 1'b0; wr_rdy = 1'b1;
        rd(2'd0, v); chk("R5 live bits", v, 32'h0000_0140);
        wreg(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R5 live after write", v, 32'h0000_0140);
        @(negedge clk);
        clk_run = 1'b0; rd_rdy = 1'b1; wr_rdy = 1'b0;
        rd(2'd0, v); chk("R5 live follow", v, 32'h0000_0080);
        rd_rdy = 1'b0;
    endtask

    task automatic t_code();
        logic [31:0] v;
        code_in = 2'd2;
        pulse(12'h004);
        code_in = 2'd1;
        rd(2'd0, v); chk("R7 code captured", v, 32'h0000_0404);
        chk("R6 err on wr crc", {31'b0, err_o}, 32'h1);
        wreg(2'd0, 32'h0000_0600);
        rd(2'd0, v); chk("R7 code write ignored", v, 32'h0000_0404);
        wreg(2'd0, 32'h0000_0004);
        rd(2'd0, v); chk("R7 code cleared", v, 32'h0);
        code_in = 2'd0;
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wreg(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R8 writable bits", v, 32'hC300_382F);
        wreg(2'd1, 32'h0);
        rd(2'd1, v); chk("R8 enable cleared", v, 32'h0);
    endtask

    task automatic t_irq();
        pulse(12'h800);                       // insertion, bit 31
        chk("R9 masked by zero enable", {31'b0, irq_o}, 32'h0);
        chk("R6 err not from insertion", {31'b0, err_o}, 32'h0);
        wreg(2'd1, 32'h4000_0000);
        chk("R9 other bit enabled", {31'b0, irq_o}, 32'h0);
        wreg(2'd1, 32'h8000_0000);
        chk("R9 matching enable", {31'b0, irq_o}, 32'h1);
        wreg(2'd0, 32'h8000_0000);
        chk("R9 cleared flag", {31'b0, irq_o}, 32'h0);
        wreg(2'd1, 32'h0);
    endtask

    task automatic t_addr();
        logic [31:0] v;
        wreg(2'd1, 32'hFFFF_FFFF);
        pulse(12'hFFF);
        rd(2'd2, v); chk("R10 addr 2", v, 32'h0);
        rd(2'd3, v); chk("R10 addr 3", v, 32'h0);
        rd(2'd0, v); chk("R10 unused status bits", v & 32'h3CFF_C010, 32'h0);
        wreg(2'd0, 32'hFFFF_FFFF);
        wreg(2'd1, 32'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_each_flag();
        t_partial_clear();
        t_set_wins();
        t_live();
        t_code();
        t_enable();
        t_irq();
        t_addr();
        finish_run();
    end

endmodule